// File: doc/BRIEF.md
# SPI FIFO Flag and Interrupt Controller

This block holds the buffering and flag logic that sits between the CPU and the shifter of a byte-wide SPI peripheral. It contains one transmit queue and one receive queue of eight bytes each, an 8-bit control register, and the logic that derives the buffer flags and one CPU interrupt request from the queue fill levels. The CPU pushes transmit bytes and pops receive bytes. The shifter pops transmit bytes and pushes received bytes.

After reset the queues act as single-byte buffers. Writing the control register with its enable bit (bit 0) set switches both queues to their full eight-byte depth and loads the other control fields at the same time. A write with bit 0 clear is discarded, so the only way back to single-byte operation is a reset. In queue mode two extra watermark flags report a transmit queue that is running low and a receive queue that is filling up. Each watermark flag has its own interrupt enable, and two select bits set the watermark levels.

Top module: `spi_fifo_flagctl`

## Requirements
- R1: After reset the control register reads 0x00, both queues are empty, the overflow indicator is 0 and the interrupt request is 0.
- R2: The control register reads back as: bit 0 queue-mode enable, bit 1 receive-watermark interrupt enable, bit 2 transmit-watermark interrupt enable, bit 3 interrupt-clear mode (stored only, with no effect on the flags), bit 4 transmit watermark select, bit 5 receive watermark select. Bits 7:6 always read 0.
- R3: A control write whose bit 0 is 0 leaves the register unchanged. A write whose bit 0 is 1 loads bits 5:0. Once queue mode is on, it stays on until reset.
- R4: In queue mode each queue holds up to 8 bytes and returns them in the order they were pushed. The head byte is visible on the read-data output while the queue is not empty.
- R5: Outside queue mode each queue holds at most 1 byte.
- R6: The receive-full flag is 1 exactly when the receive queue holds as many bytes as the current depth (8 or 1). The transmit-empty flag is 1 exactly when the transmit queue holds no byte.
- R7: The transmit near-empty flag is 1 in queue mode when the transmit count is at most 2 (bit 4 = 0) or at most 4 (bit 4 = 1). It is 0 outside queue mode.
- R8: The receive nearly-full flag is 1 in queue mode when the receive count is at least 6 (bit 5 = 0) or at least 4 (bit 5 = 1). It is 0 outside queue mode.
- R9: The interrupt request is the OR of four terms: receive-full AND the receive interrupt enable input, transmit-empty AND the transmit interrupt enable input, near-empty AND bit 2, nearly-full AND bit 1.
- R10: A push into a full queue and a pop from an empty queue are ignored. A push and a pop to the same queue in the same cycle are each judged against the count before that edge. A dropped push on either queue sets a sticky overflow indicator that only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| buf_rx_ie | input | 1 | Receive-full interrupt enable |
| buf_tx_ie | input | 1 | Transmit-empty interrupt enable |
| tx_push | input | 1 | CPU push into the transmit queue |
| tx_wdata | input | 8 | Byte pushed into the transmit queue |
| tx_pop | input | 1 | Shifter pop from the transmit queue |
| tx_rdata | output | 8 | Head byte of the transmit queue |
| rx_push | input | 1 | Shifter push into the receive queue |
| rx_wdata | input | 8 | Byte pushed into the receive queue |
| rx_pop | input | 1 | CPU pop from the receive queue |
| rx_rdata | output | 8 | Head byte of the receive queue |
| rx_full_flag | output | 1 | Receive queue full |
| tx_empty_flag | output | 1 | Transmit queue empty |
| tx_near_empty_flag | output | 1 | Transmit watermark reached |
| rx_near_full_flag | output | 1 | Receive watermark reached |
| ovf_sticky | output | 1 | Sticky dropped-push indicator |
| irq | output | 1 | CPU interrupt request |

## Verification
The assertions assume the following about the inputs:
- Every push and pop strobe is a level that the block samples once per rising edge, so holding a strobe high for several cycles means several requests.
- A strobe may arrive when the queue cannot accept it.
- Reset is applied asynchronously and the assertions are off while it is active.

The stimulus stays within these assumptions:
- It changes inputs only at the falling edge.
- It mixes push and pop rates in segments, so that both queues regularly reach full and empty.
- It drops control writes in randomly, and half of them have bit 0 forced to 1.
- In the single-byte phase it keeps bit 0 clear, so that phase covers discarded writes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int TXNE_LVL_A = 2;
  localparam int TXNE_LVL_B = 4;
  localparam int RXNF_LVL_A = 6;
  localparam int RXNF_LVL_B = 4;

  // Control fields, msb first: bit5 .. bit0
  typedef struct packed {
    logic rx_wm_sel;
    logic tx_wm_sel;
    logic int_clr_mode;
    logic txne_ie;
    logic rxnf_ie;
    logic fifo_en;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] active_depth(input logic fifo_en);
    return fifo_en ? CNT_W'(FIFO_DEPTH) : CNT_W'(1);
  endfunction

  function automatic logic near_empty(input logic [CNT_W-1:0] cnt, input logic sel);
    return cnt <= CNT_W'(sel ? TXNE_LVL_B : TXNE_LVL_A);
  endfunction

  function automatic logic near_full(input logic [CNT_W-1:0] cnt, input logic sel);
    return cnt >= CNT_W'(sel ? RXNF_LVL_B : RXNF_LVL_A);
  endfunction
endpackage

// File: rtl/sfc_ctrl_reg.sv
module sfc_ctrl_reg
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output ctrl_t      ctrl,
  output logic [7:0] rdata
);
  logic wr_take;
  assign wr_take = wr_en && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_take) ctrl <= ctrl_t'(wdata[5:0]);
  end

  assign rdata = {2'b00, ctrl};

  // R3
  ign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[0]) |=> $stable(ctrl));
  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ctrl.fifo_en));
endmodule

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              push_drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cur_depth;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign cur_depth = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign push_ok   = push && (count < cur_depth);
  assign pop_ok    = pop && (count != '0);
  assign push_drop = push && !push_ok;
  assign rdata     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R4 R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cur_depth);
  // R10
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == cur_depth) |=> $stable(count));
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0) |=> (count == '0));
endmodule

// File: rtl/spi_fifo_flagctl.sv
module spi_fifo_flagctl
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       buf_rx_ie,
  input  logic       buf_tx_ie,
  input  logic       tx_push,
  input  logic [7:0] tx_wdata,
  input  logic       tx_pop,
  output logic [7:0] tx_rdata,
  input  logic       rx_push,
  input  logic [7:0] rx_wdata,
  input  logic       rx_pop,
  output logic [7:0] rx_rdata,
  output logic       rx_full_flag,
  output logic       tx_empty_flag,
  output logic       tx_near_empty_flag,
  output logic       rx_near_full_flag,
  output logic       ovf_sticky,
  output logic       irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_drop, rx_drop;
  logic             irq_rxf, irq_txe, irq_txne, irq_rxnf;

  sfc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .ctrl(ctrl), .rdata(reg_rdata)
  );

  sfc_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .fifo_en(ctrl.fifo_en),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_cnt), .push_drop(tx_drop)
  );

  sfc_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .fifo_en(ctrl.fifo_en),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_cnt), .push_drop(rx_drop)
  );

  assign rx_full_flag       = (rx_cnt == active_depth(ctrl.fifo_en));
  assign tx_empty_flag      = (tx_cnt == '0);
  assign tx_near_empty_flag = ctrl.fifo_en && near_empty(tx_cnt, ctrl.tx_wm_sel);
  assign rx_near_full_flag  = ctrl.fifo_en && near_full(rx_cnt, ctrl.rx_wm_sel);

  assign irq_rxf  = rx_full_flag && buf_rx_ie;
  assign irq_txe  = tx_empty_flag && buf_tx_ie;
  assign irq_txne = tx_near_empty_flag && ctrl.txne_ie;
  assign irq_rxnf = rx_near_full_flag && ctrl.rxnf_ie;
  assign irq      = irq_rxf || irq_txe || irq_txne || irq_rxnf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovf_sticky <= 1'b0;
    else if (tx_drop || rx_drop) ovf_sticky <= 1'b1;
  end

  // R10
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ovf_sticky));
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_full_flag || tx_empty_flag || tx_near_empty_flag || rx_near_full_flag));
  // R7 R8
  wm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.fifo_en |-> !(tx_near_empty_flag || rx_near_full_flag));
endmodule

// File: tb/test_spi_fifo_flagctl.sv
module test_spi_fifo_flagctl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, buf_rx_ie = 0, buf_tx_ie = 0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] reg_wdata = 0, tx_wdata = 0, rx_wdata = 0;
  logic [7:0] reg_rdata, tx_rdata, rx_rdata;
  logic rx_full_flag, tx_empty_flag, tx_near_empty_flag, rx_near_full_flag, ovf_sticky, irq;

  int errors = 0, checks = 0;
  int tq[$], rq[$];
  logic [5:0] mc = 0;
  bit movf = 0;

  always #4 clk = ~clk;

  spi_fifo_flagctl i_spi_fifo_flagctl (.*);

  function automatic int depth_of(input logic [5:0] c); return c[0] ? 8 : 1; endfunction
  function automatic bit exp_ne(input int n, input logic [5:0] c);
    return c[0] && (n <= (c[4] ? 4 : 2));
  endfunction
  function automatic bit exp_nf(input int n, input logic [5:0] c);
    return c[0] && (n >= (c[5] ? 4 : 6));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ef, ff, ne, nf;
    ef = (tq.size() == 0);
    ff = (rq.size() == depth_of(mc));
    ne = exp_ne(tq.size(), mc);
    nf = exp_nf(rq.size(), mc);
    chk("R2 ctrl readback", reg_rdata, {2'b00, mc});
    chk("R6 tx empty", tx_empty_flag, ef);
    chk("R6 rx full", rx_full_flag, ff);
    chk("R7 tx near-empty", tx_near_empty_flag, ne);
    chk("R8 rx nearly-full", rx_near_full_flag, nf);
    chk("R9 irq", irq, (ff && buf_rx_ie) || (ef && buf_tx_ie) || (ne && mc[2]) || (nf && mc[1]));
    chk("R10 overflow sticky", ovf_sticky, movf);
    if (tq.size() > 0) chk(mc[0] ? "R4 tx head" : "R5 tx head", tx_rdata, tq[0]);
    if (rq.size() > 0) chk(mc[0] ? "R4 rx head" : "R5 rx head", rx_rdata, rq[0]);
  endtask

  task automatic step(input bit wr, input logic [7:0] wd, input bit tp, input logic [7:0] td,
                      input bit tpo, input bit rp, input logic [7:0] rd, input bit rpo);
    int dep;
    bit tok, rok;
    reg_wr = wr; reg_wdata = wd; tx_push = tp; tx_wdata = td; tx_pop = tpo;
    rx_push = rp; rx_wdata = rd; rx_pop = rpo;
    @(posedge clk);
    dep = depth_of(mc);
    tok = tp && (tq.size() < dep);
    rok = rp && (rq.size() < dep);
    if ((tp && !tok) || (rp && !rok)) movf = 1;
    if (tpo && tq.size() > 0) void'(tq.pop_front());
    if (rpo && rq.size() > 0) void'(rq.pop_front());
    if (tok) tq.push_back(td);
    if (rok) rq.push_back(rd);
    if (wr && wd[0]) mc = wd[5:0];
    @(negedge clk);
    reg_wr = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0;
    reg_wr = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tq.delete(); rq.delete(); mc = 0; movf = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic rand_phase(input int n, input bit allow_mode);
    int pt = 50, pr = 50;
    for (int i = 0; i < n; i++) begin
      logic [7:0] wd;
      if (i % 200 == 0) begin
        pt = $urandom_range(10, 90);
        pr = $urandom_range(10, 90);
        buf_rx_ie = 1'($urandom);
        buf_tx_ie = 1'($urandom);
      end
      wd = 8'($urandom);
      if (allow_mode && $urandom_range(0, 1) == 1) wd[0] = 1'b1;
      if (!allow_mode) wd[0] = 1'b0;
      step(($urandom_range(0, 15) == 0), wd,
           ($urandom_range(0, 99) < pt), 8'($urandom), ($urandom_range(0, 99) >= pt),
           ($urandom_range(0, 99) < pr), 8'($urandom), ($urandom_range(0, 99) >= pr));
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R1 reset state
    chk("R1 ctrl after reset", reg_rdata, 8'h00);
    chk("R1 tx empty after reset", tx_empty_flag, 1);
    chk("R1 rx full after reset", rx_full_flag, 0);
    chk("R1 overflow after reset", ovf_sticky, 0);
    chk("R1 irq after reset", irq, 0);

    // R3 write with bit0 clear is discarded
    step(1, 8'hFE, 0, 0, 0, 0, 0, 0);
    chk("R3 ignored write", reg_rdata, 8'h00);

    // R5 single-byte depth, R10 dropped push
    step(0, 0, 1, 8'hA5, 0, 1, 8'h3C, 0);
    step(0, 0, 1, 8'h11, 0, 1, 8'h22, 0);
    chk("R5 tx holds first byte", tx_rdata, 8'hA5);
    chk("R10 drop sets sticky", ovf_sticky, 1);
    buf_rx_ie = 1;
    @(negedge clk);
    chk("R9 rx-full irq", irq, 1);
    buf_rx_ie = 0;

    // R3 enable queue mode with all fields; bit 3 stored only
    do_reset();
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0);
    chk("R2 upper bits read 0", reg_rdata, 8'h3F);
    step(1, 8'h00, 0, 0, 0, 0, 0, 0);
    chk("R3 mode stays on", reg_rdata[0], 1);

    // R4 fill receive queue to 8, check order and watermark at 4 (sel=1)
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 0, 1, 8'(i + 8'h40), 0);
    chk("R4 rx full at 8", rx_full_flag, 1);
    chk("R10 ninth push dropped", ovf_sticky, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R4 rx order", rx_rdata, i + 8'h40);
      step(0, 0, 0, 0, 0, 0, 0, 1);
    end
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 pop empty ignored", rx_full_flag, 0);

    // R7 R8 select 0 thresholds
    step(1, 8'h07, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 8'(i), 0, 0, 0, 0);
    chk("R7 count 3 not near-empty", tx_near_empty_flag, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 8'(i), 0);
    chk("R8 count 6 nearly-full", rx_near_full_flag, 1);

    // random coverage: single-byte phase then queue phase
    do_reset();
    rand_phase(600, 0);
    step(1, 8'h01, 0, 0, 0, 0, 0, 0);
    rand_phase(4000, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule